// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block turns single host requests into timed asynchronous NAND flash bus cycles. A request carries one of four kinds: a command byte, an address byte, a data write or a data read. The block runs that one cycle on the flash pins: chip enable, the command and address latch strobes, the write and read strobes, and the data output enable. It returns read data to the host. Page sequencing, error correction and bulk transfer engines sit above it and issue requests one at a time.

Every cycle is made of four phases, each counted in system clocks from its own 8-bit field of a timing word. The phases are a setup lead-in, a strobe pulse, a hold tail and, after reads only, a bus turnaround gap. A control word enables the bank, selects an 8- or 16-bit data lane and enables waiting on the flash ready/busy line. It also holds two 4-bit delays. One is inserted before a read strobe that directly follows a command cycle, the other before one that directly follows an address cycle. Both words are written through a small configuration port and should only be changed while no cycle is running.

Top module: `nfc_cycle_timer`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) nand_ce_n, nand_we_n and nand_re_n are 1. nand_cle, nand_ale, nand_dq_oe, rd_valid, busy and req_ready are 0. Both configuration words are zero.
- R2: req_ready is 1 only when no cycle is running and all of these hold: control bit 2 (enable) is 1, control bit 3 (NAND device select) is 1, control bit 0 (bank reset) is 0, and waiting is not blocked by R11. A req_valid while req_ready is 0 starts no cycle. Setting bank reset returns the block to idle.
- R3: req_kind codes are 0 = command, 1 = address, 2 = data write, 3 = data read. nand_cle is 1 for the whole chip-enable window of a command cycle and 0 otherwise. nand_ale is 1 for the whole window of an address cycle and 0 otherwise.
- R4: cfg_addr 0 selects the control word and cfg_addr 1 the timing word. In the timing word the setup count S is in bits 7:0, the strobe count W in bits 15:8, the hold count H in bits 23:16 and the turnaround count Z in bits 31:24. nand_ce_n falls S+1 clocks before the strobe starts, plus any read delay from R9.
- R5: The strobe lasts W+1 clocks. It is nand_we_n low for kinds 0, 1 and 2, and nand_re_n low for kind 3. The two are never low together.
- R6: nand_ce_n stays low for H clocks after the strobe ends, so H = 0 raises it together with the strobe.
- R7: For write kinds, nand_dq_oe is 1 throughout the chip-enable window and nand_dq_o carries req_wdata. With control bit 4 clear (8-bit lane), nand_dq_o[15:8] is 0. For reads nand_dq_oe stays 0.
- R8: A read samples nand_dq_i on the last strobe clock. rd_valid is a one-clock pulse in the following clock, carrying the sample in rd_data, with bits 15:8 zero in 8-bit mode. It does not pulse for write kinds.
- R9: A read directly after a command cycle adds control bits 12:9 clocks between setup and strobe. A read directly after an address cycle adds control bits 16:13 clocks. Any other read, and every write, adds none.
- R10: After a read, req_ready stays 0 for Z clocks after nand_ce_n rises. After writes no such gap is added.
- R11: busy equals the inverse of nand_rb_n delayed by two clocks. When control bit 1 (wait enable) is 1, busy holds req_ready at 0. When it is 0, busy does not block requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = control word, 1 = timing word |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | Request kind code (R3) |
| req_wdata | input | 16 | Byte or word to drive for write kinds |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 16 | Data captured by the last read |
| busy | output | 1 | Synchronized flash busy indication |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Data driven to flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 16 | Data returned by flash |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
A phase counter that loads or reloads the wrong value shows up in the very cycle it runs. It stretches or shortens the chip-enable lead-in, the strobe width or the hold tail, and the bench measures each of these clock by clock against the programmed fields. A stale remembered request kind shows up only on the next read, as a missing or wrong delay before the read strobe. A bad read capture point shows up one clock after the strobe, as a wrong rd_data value or a misplaced rd_valid pulse. A turnaround or busy-gating fault shows up in the clocks after a cycle, as req_ready returning too early or too late.

// File: rtl/nfc_pkg.sv
// Shared types and word layouts for the NAND bus cycle timer.
// Assumes a single bank and one outstanding request at a time.
package nfc_pkg;

    localparam int PH_W  = 8;   // width of every phase count field
    localparam int DLY_W = 4;   // width of the latch-to-read delays
    localparam int CFG_W = 32;  // configuration word width

    // control word bit positions
    localparam int CTL_BANKRST = 0;
    localparam int CTL_WAITEN  = 1;
    localparam int CTL_ENABLE  = 2;
    localparam int CTL_NAND    = 3;
    localparam int CTL_WIDE    = 4;
    localparam int CTL_CLE_LSB = 9;
    localparam int CTL_ALE_LSB = 13;

    // timing word field positions
    localparam int TIM_SET_LSB = 0;
    localparam int TIM_STB_LSB = 8;
    localparam int TIM_HLD_LSB = 16;
    localparam int TIM_HIZ_LSB = 24;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_GAP    = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_HIZ    = 3'd5
    } phase_e;

    typedef struct packed {
        logic             bank_rst;
        logic             wait_en;
        logic             enable;
        logic             nand_sel;
        logic             wide;
        logic [DLY_W-1:0] cle_re;
        logic [DLY_W-1:0] ale_re;
    } ctrl_t;

    typedef struct packed {
        logic [PH_W-1:0] hiz;
        logic [PH_W-1:0] hold;
        logic [PH_W-1:0] strobe;
        logic [PH_W-1:0] setup;
    } timing_t;

endpackage

// File: rtl/nfc_cfg_regs.sv
// Control and timing registers, written through a one-bit addressed port.
// Assumes software writes them only while the bus is idle.
module nfc_cfg_regs
    import nfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output ctrl_t            ctrl_o,
    output timing_t          timing_o
);

    ctrl_t   ctrl_q;
    timing_t timing_q;

    // unused control bits are discarded on write
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:CTL_ALE_LSB+DLY_W],
                               cfg_wdata[CTL_CLE_LSB-1:CTL_WIDE+1]};

    // register update on configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            timing_q <= '0;
        end else if (cfg_we) begin
            if (!cfg_addr) begin
                ctrl_q.bank_rst <= cfg_wdata[CTL_BANKRST];
                ctrl_q.wait_en  <= cfg_wdata[CTL_WAITEN];
                ctrl_q.enable   <= cfg_wdata[CTL_ENABLE];
                ctrl_q.nand_sel <= cfg_wdata[CTL_NAND];
                ctrl_q.wide     <= cfg_wdata[CTL_WIDE];
                ctrl_q.cle_re   <= cfg_wdata[CTL_CLE_LSB +: DLY_W];
                ctrl_q.ale_re   <= cfg_wdata[CTL_ALE_LSB +: DLY_W];
            end else begin
                timing_q.setup  <= cfg_wdata[TIM_SET_LSB +: PH_W];
                timing_q.strobe <= cfg_wdata[TIM_STB_LSB +: PH_W];
                timing_q.hold   <= cfg_wdata[TIM_HLD_LSB +: PH_W];
                timing_q.hiz    <= cfg_wdata[TIM_HIZ_LSB +: PH_W];
            end
        end
    end

    assign ctrl_o   = ctrl_q;
    assign timing_o = timing_q;

endmodule

// File: rtl/nfc_rb_sync.sv
// Brings the asynchronous ready/busy line into the clock domain.
// Assumes the line idles high (ready); busy is its synchronized inverse.
module nfc_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_i,
    output logic busy_o
);

    logic [STAGES-1:0] sync_q;

    // shift chain, reset to the ready level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], rb_n_i};
    end

    assign busy_o = ~sync_q[STAGES-1];

    // R11
    busy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_q[0]) |=> busy_o);

endmodule

// File: rtl/nfc_phase_seq.sv
// Phase sequencer: accepts one request, then walks setup, optional read
// delay, strobe, hold and (reads only) turnaround, each from its own count.
// Assumes timing is sampled at acceptance; a count of zero skips hold,
// delay and turnaround but setup and strobe always last at least one clock.
module nfc_phase_seq
    import nfc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_i,
    input  timing_t           timing_i,
    input  logic              busy_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output phase_e            phase_o,
    output op_kind_e          kind_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              strobe_last_o
);

    localparam int PAD_W = PH_W - DLY_W;

    phase_e            phase_q;
    logic [PH_W-1:0]   cnt_q;
    op_kind_e          kind_q;
    op_kind_e          last_kind_q;
    logic [DATA_W-1:0] wdata_q;
    timing_t           tim_q;
    logic [DLY_W-1:0]  gap_q;

    logic             issue_ok;
    logic             accept;
    op_kind_e         req_kind;
    logic [DLY_W-1:0] gap_next;
    logic             cnt_done;

    // request gating
    assign req_kind    = op_kind_e'(req_kind_i);
    assign issue_ok    = ctrl_i.enable && ctrl_i.nand_sel && !ctrl_i.bank_rst
                         && !(ctrl_i.wait_en && busy_i);
    assign req_ready_o = (phase_q == PH_IDLE) && issue_ok;
    assign accept      = req_ready_o && req_valid_i;
    assign cnt_done    = (cnt_q == '0);

    // delay before a read strobe chosen by the previous cycle's kind
    always_comb begin
        gap_next = '0;
        if (req_kind == OP_RD) begin
            if (last_kind_q == OP_CMD)       gap_next = ctrl_i.cle_re;
            else if (last_kind_q == OP_ADDR) gap_next = ctrl_i.ale_re;
        end
    end

    // phase walk and counter reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            kind_q      <= OP_WR;
            last_kind_q <= OP_WR;
            wdata_q     <= '0;
            tim_q       <= '0;
            gap_q       <= '0;
        end else if (ctrl_i.bank_rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        kind_q      <= req_kind;
                        last_kind_q <= req_kind;
                        wdata_q     <= req_wdata_i;
                        tim_q       <= timing_i;
                        gap_q       <= gap_next;
                        cnt_q       <= timing_i.setup;
                        phase_q     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (!cnt_done) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (gap_q != '0) begin
                        cnt_q   <= {{PAD_W{1'b0}}, gap_q - 1'b1};
                        phase_q <= PH_GAP;
                    end else begin
                        cnt_q   <= tim_q.strobe;
                        phase_q <= PH_STROBE;
                    end
                end
                PH_GAP: begin
                    if (!cnt_done) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cnt_q   <= tim_q.strobe;
                        phase_q <= PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    if (!cnt_done) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (tim_q.hold != '0) begin
                        cnt_q   <= tim_q.hold - 1'b1;
                        phase_q <= PH_HOLD;
                    end else if (kind_q == OP_RD && tim_q.hiz != '0) begin
                        cnt_q   <= tim_q.hiz - 1'b1;
                        phase_q <= PH_HIZ;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_HOLD: begin
                    if (!cnt_done) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (kind_q == OP_RD && tim_q.hiz != '0) begin
                        cnt_q   <= tim_q.hiz - 1'b1;
                        phase_q <= PH_HIZ;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_HIZ: begin
                    if (!cnt_done) cnt_q   <= cnt_q - 1'b1;
                    else           phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o       = phase_q;
    assign kind_o        = kind_q;
    assign wdata_o       = wdata_q;
    assign strobe_last_o = (phase_q == PH_STROBE) && cnt_done;

    // R2
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !(req_valid_i && req_ready_o)) |=> phase_q == PH_IDLE);

    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && !cnt_done && !ctrl_i.bank_rst) |=> phase_q == PH_STROBE);

    // R10
    hiz_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_HIZ |-> kind_q == OP_RD);

endmodule

// File: rtl/nfc_pin_drive.sv
// Flash pin decode from the current phase and kind, plus read data capture.
// Assumes the phase input is registered so the pins change only after edges.
module nfc_pin_drive
    import nfc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_rst_i,
    input  logic              wide_i,
    input  phase_e            phase_i,
    input  op_kind_e          kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              strobe_last_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              ce_n_o,
    output logic              cle_o,
    output logic              ale_o,
    output logic              we_n_o,
    output logic              re_n_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int BYTE_W = 8;

    logic [DATA_W-1:0] lane_mask;
    logic              window;
    logic              is_read;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    // lane mask: upper lanes cleared in byte mode
    generate
        if (DATA_W > BYTE_W) begin : g_wide_bus
            assign lane_mask = wide_i ? {DATA_W{1'b1}}
                                      : {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        end else begin : g_byte_bus
            logic unused_wide;
            assign unused_wide = wide_i;
            assign lane_mask   = {DATA_W{1'b1}};
        end
    endgenerate

    // pin decode
    assign window  = (phase_i == PH_SETUP) || (phase_i == PH_GAP)
                  || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
    assign is_read = (kind_i == OP_RD);
    assign ce_n_o  = !window;
    assign cle_o   = window && (kind_i == OP_CMD);
    assign ale_o   = window && (kind_i == OP_ADDR);
    assign we_n_o  = !((phase_i == PH_STROBE) && !is_read);
    assign re_n_o  = !((phase_i == PH_STROBE) && is_read);
    assign dq_oe_o = window && !is_read;
    assign dq_o    = dq_oe_o ? (wdata_i & lane_mask) : '0;

    // read sample on the final strobe clock
    always_ff @(posedge clk) begin
        if (!rst_n || bank_rst_i) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= strobe_last_i && is_read;
            if (strobe_last_i && is_read) rd_data_q <= dq_i & lane_mask;
        end
    end

    assign rd_valid_o = rd_valid_q;
    assign rd_data_o  = rd_data_q;

    // R3
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !re_n_o));

    // R7
    oe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> !ce_n_o);

    // R8
    rdv_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(strobe_last_i && is_read));

endmodule

// File: rtl/nfc_cycle_timer.sv
// Top of the NAND bus cycle timer: configuration registers, ready/busy
// synchronizer, phase sequencer and pin driver.
// Assumes one flash bank and a host that waits for req_ready.
module nfc_cycle_timer
    import nfc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int RB_STAGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rb_n
);

    ctrl_t             ctrl;
    timing_t           timing;
    phase_e            phase;
    op_kind_e          kind;
    logic [DATA_W-1:0] wdata;
    logic              strobe_last;

    nfc_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl_o    (ctrl),
        .timing_o  (timing)
    );

    nfc_rb_sync #(.STAGES(RB_STAGE)) u_rb (
        .clk    (clk),
        .rst_n  (rst_n),
        .rb_n_i (nand_rb_n),
        .busy_o (busy)
    );

    nfc_phase_seq #(.DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_i        (ctrl),
        .timing_i      (timing),
        .busy_i        (busy),
        .req_valid_i   (req_valid),
        .req_kind_i    (req_kind),
        .req_wdata_i   (req_wdata),
        .req_ready_o   (req_ready),
        .phase_o       (phase),
        .kind_o        (kind),
        .wdata_o       (wdata),
        .strobe_last_o (strobe_last)
    );

    nfc_pin_drive #(.DATA_W(DATA_W)) u_pins (
        .clk           (clk),
        .rst_n         (rst_n),
        .bank_rst_i    (ctrl.bank_rst),
        .wide_i        (ctrl.wide),
        .phase_i       (phase),
        .kind_i        (kind),
        .wdata_i       (wdata),
        .strobe_last_i (strobe_last),
        .dq_i          (nand_dq_i),
        .ce_n_o        (nand_ce_n),
        .cle_o         (nand_cle),
        .ale_o         (nand_ale),
        .we_n_o        (nand_we_n),
        .re_n_o        (nand_re_n),
        .dq_o          (nand_dq_o),
        .dq_oe_o       (nand_dq_oe),
        .rd_valid_o    (rd_valid),
        .rd_data_o     (rd_data)
    );

    // R11
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl.wait_en && $past(busy)) |-> !(req_ready && nand_ce_n && $rose(nand_ce_n)));

endmodule

// File: tb/nfc_cycle_timer_tb_top.sv
// Scoreboard bench: the driver pushes expected cycle shapes, the monitor
// measures each cycle at the pins and compares.
module nfc_cycle_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rd_valid, busy;
    logic [15:0] rd_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_o;
    logic [15:0] nand_dq_i = '0;
    logic        nand_rb_n = 1'b1;

    always #5 clk = ~clk;

    nfc_cycle_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    typedef struct {
        int kind; int pre; int st; int post; int hiz; int gap;
        int dout; int rdat;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   mon_busy = 0;

    // bench copy of programmed settings
    int tm_s = 0, tm_w = 0, tm_h = 0, tm_z = 0;
    int c_wide = 0, c_cle = 0, c_ale = 0;
    int lastk = 2;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic cfg_write(input bit a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // timing word: setup 7:0, strobe 15:8, hold 23:16, turnaround 31:24 (R4)
    task automatic set_timing(input int s, input int w, input int h, input int z);
        tm_s = s; tm_w = w; tm_h = h; tm_z = z;
        cfg_write(1'b1, {z[7:0], h[7:0], w[7:0], s[7:0]});
    endtask

    task automatic set_ctrl(input bit brst, input bit wen, input bit en, input bit nand_s,
                            input bit wide, input int cle_d, input int ale_d);
        logic [31:0] w;
        w = '0;
        w[0] = brst; w[1] = wen; w[2] = en; w[3] = nand_s; w[4] = wide;
        w[12:9] = cle_d[3:0]; w[16:13] = ale_d[3:0];
        c_wide = wide; c_cle = cle_d; c_ale = ale_d;
        cfg_write(1'b0, w);
    endtask

    task automatic push_item(input int kind, input int wd, input int rdv);
        exp_t e;
        int   mask;
        mask = c_wide ? 32'hFFFF : 32'h00FF;
        e.gap = 0;
        if (kind == 3 && lastk == 0) e.gap = c_cle;
        if (kind == 3 && lastk == 1) e.gap = c_ale;
        lastk  = kind;
        e.kind = kind;
        e.pre  = tm_s + 1 + e.gap;
        e.st   = tm_w + 1;
        e.post = tm_h;
        e.hiz  = (kind == 3) ? tm_z : 0;
        e.dout = wd & mask;
        e.rdat = rdv & mask;
        nand_dq_i = rdv[15:0];
        q.push_back(e);
        mon_busy = 1;
    endtask

    task automatic issue(input int kind, input int wd);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind[1:0]; req_wdata = wd[15:0];
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (mon_busy) @(negedge clk);
    endtask

    task automatic do_op(input int kind, input int wd, input int rdv);
        push_item(kind, wd, rdv);
        issue(kind, wd);
        wait_done();
    endtask

    // monitor state
    bit   in_cyc = 0, hiz_act = 0;
    int   ph = 0, n_pre = 0, n_st = 0, n_post = 0, n_hiz = 0;
    bit   cle_ok, ale_ok, oe_ok, dout_ok, re_seen, we_seen;
    exp_t cur;

    always @(negedge clk) begin
        if (!rst_n) begin
            in_cyc  = 0;
            hiz_act = 0;
        end else begin
            if (!in_cyc && !nand_ce_n) begin
                in_cyc = 1; ph = 0; n_pre = 0; n_st = 0; n_post = 0;
                cle_ok = 1; ale_ok = 1; oe_ok = 1; dout_ok = 1;
                re_seen = 0; we_seen = 0;
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected cycle", 1, 0);
                    cur = '{default: 0};
                end else begin
                    cur = q.pop_front();
                end
            end
            if (in_cyc) begin
                if (!nand_ce_n) begin
                    if (nand_cle != (cur.kind == 0)) cle_ok = 0;
                    if (nand_ale != (cur.kind == 1)) ale_ok = 0;
                    if (nand_dq_oe != (cur.kind != 3)) oe_ok = 0;
                    if (cur.kind != 3 && nand_dq_o != cur.dout[15:0]) dout_ok = 0;
                end
                if (!nand_re_n) re_seen = 1;
                if (!nand_we_n) we_seen = 1;
                case (ph)
                    0: if (!nand_we_n || !nand_re_n) begin ph = 1; n_st = 1; end
                       else n_pre++;
                    1: if (!nand_we_n || !nand_re_n) n_st++;
                       else begin
                           ph = 2;
                           chk(rd_valid == (cur.kind == 3), "R8 rd_valid after strobe",
                               rd_valid, cur.kind == 3);
                           if (cur.kind == 3)
                               chk(rd_data == cur.rdat[15:0], "R8 rd_data", rd_data, cur.rdat);
                       end
                    default: ;
                endcase
                if (ph == 2 && !nand_ce_n) n_post++;
                if (nand_ce_n) begin
                    in_cyc = 0;
                    chk(n_pre == cur.pre, (cur.gap != 0) ? "R9 lead-in with read delay" : "R4 lead-in",
                        n_pre, cur.pre);
                    chk(n_st == cur.st, "R5 strobe width", n_st, cur.st);
                    chk(re_seen == (cur.kind == 3) && we_seen == (cur.kind != 3),
                        "R5 strobe pin", {re_seen, we_seen}, cur.kind);
                    chk(n_post == cur.post, "R6 hold", n_post, cur.post);
                    chk(cle_ok && ale_ok, "R3 latch enables", {cle_ok, ale_ok}, 3);
                    chk(oe_ok, "R7 output enable", oe_ok, 1);
                    if (cur.kind != 3) chk(dout_ok, "R7 write data", nand_dq_o, cur.dout);
                    if (cur.kind == 3) begin hiz_act = 1; n_hiz = 0; end
                    else mon_busy = 0;
                end
            end
            if (hiz_act) begin
                if (!req_ready) n_hiz++;
                else begin
                    chk(n_hiz == cur.hiz, "R10 turnaround", n_hiz, cur.hiz);
                    hiz_act = 0;
                    mon_busy = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit saw_ce;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle",
            {nand_ce_n, nand_we_n, nand_re_n}, 7);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches idle",
            {nand_cle, nand_ale, nand_dq_oe}, 0);
        chk(!rd_valid && !busy && !req_ready, "R1 host side idle",
            {rd_valid, busy, req_ready}, 0);
        rst_n = 1'b1;

        // R2 gating: not enabled, not NAND, bank reset
        @(negedge clk);
        chk(!req_ready, "R2 ready with zero control", req_ready, 0);
        set_ctrl(0, 0, 0, 1, 1, 3, 5);
        @(negedge clk);
        chk(!req_ready, "R2 ready without enable", req_ready, 0);
        set_ctrl(0, 0, 1, 0, 1, 3, 5);
        @(negedge clk);
        chk(!req_ready, "R2 ready without device select", req_ready, 0);
        set_ctrl(1, 0, 1, 1, 1, 3, 5);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd2; req_wdata = 16'h1111;
        saw_ce = 0;
        repeat (6) begin @(negedge clk); if (!nand_ce_n) saw_ce = 1; end
        req_valid = 1'b0;
        chk(!saw_ce && !req_ready, "R2 bank reset blocks cycles", saw_ce, 0);

        // normal 16-bit run
        set_ctrl(0, 0, 1, 1, 1, 3, 5);
        set_timing(2, 3, 1, 2);
        @(negedge clk);
        chk(req_ready, "R2 ready when enabled", req_ready, 1);
        do_op(0, 16'h0090, 0);
        do_op(3, 0, 16'hBEEF);
        do_op(1, 16'h0000, 0);
        do_op(3, 0, 16'h1357);
        do_op(2, 16'hA5C3, 0);
        do_op(3, 0, 16'h2468);

        // minimal timing
        set_timing(0, 0, 0, 0);
        do_op(2, 16'h0F0F, 0);
        do_op(3, 0, 16'h8001);
        do_op(0, 16'h00FF, 0);
        do_op(3, 0, 16'h7E7E);

        // byte lane
        set_ctrl(0, 0, 1, 1, 0, 2, 1);
        set_timing(1, 5, 3, 4);
        do_op(2, 16'hABCD, 0);
        do_op(1, 16'h1234, 0);
        do_op(3, 0, 16'h1234);

        // full-range fields
        set_timing(255, 255, 255, 9);
        do_op(2, 16'h5A5A, 0);
        set_timing(1, 2, 0, 3);

        // R11 busy gating with wait enable
        set_ctrl(0, 1, 1, 1, 1, 3, 5);
        @(negedge clk);
        nand_rb_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy, "R11 busy after sync", busy, 1);
        chk(!req_ready, "R11 ready held while busy", req_ready, 0);
        push_item(2, 16'hC0DE, 0);
        req_valid = 1'b1; req_kind = 2'd2; req_wdata = 16'hC0DE;
        saw_ce = 0;
        repeat (8) begin @(negedge clk); if (!nand_ce_n) saw_ce = 1; end
        chk(!saw_ce, "R11 no cycle while busy", saw_ce, 0);
        nand_rb_n = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        wait_done();
        chk(!busy, "R11 busy clears", busy, 0);

        // R11 busy ignored without wait enable
        set_ctrl(0, 0, 1, 1, 1, 3, 5);
        nand_rb_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy && req_ready, "R11 busy does not block", {busy, req_ready}, 3);
        do_op(3, 0, 16'h4321);
        nand_rb_n = 1'b1;

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R2 all expected cycles seen", q.size(), 0);
        finish_run();
    end

endmodule